// File: doc/BRIEF.md
# Accumulator Register-Operation Execute Unit

This unit carries out the register-operation class of instructions for a small 16-bit accumulator machine. It holds the 16-bit accumulator and a one-bit extend (carry) flag. An instruction qualifies when its three opcode bits [14:12] are 111 and its indirect bit [15] is 0. Each of the twelve low bits [11:0] then names one operation. The operations clear, complement, rotate or increment the accumulator and flag, test them to request a skip of the next instruction, or stop the machine.

The fetch sequencer presents a full 16-bit instruction word together with a one-cycle execute strobe. The unit updates its state on that clock edge. The program counter lives outside the unit and only sees the skip request. The halt output is meant to stop the sequencer.

Top module: `regref_exec_unit`

## Requirements
- R1: While reset is high, and after it, the accumulator reads 0000, the extend flag 0, the skip output 0 and the halt output 0.
- R2: Word 7800 clears the accumulator and 7200 inverts every accumulator bit. Word 7400 clears the extend flag and 7100 inverts it. The result is visible the cycle after the strobe.
- R3: Word 7080 rotates the 17-bit pair {E, AC} right. The old E goes into AC[15] and the old AC[0] goes into E.
- R4: Word 7040 rotates the pair left. The old E goes into AC[0] and the old AC[15] goes into E.
- R5: Word 7020 adds one to the accumulator, wrapping FFFF to 0000, and leaves E unchanged.
- R6: Word 7010 requests a skip when AC[15] is 0 (zero counts as positive). Word 7008 requests a skip when AC[15] is 1.
- R7: Word 7004 requests a skip when all 16 accumulator bits are 0. Word 7002 requests a skip when E is 0.
- R8: A skip request is a pulse lasting exactly the one cycle after the strobe. Skip tests and halt leave AC and E unchanged.
- R9: Word 7001 sets the halt output in the cycle after the strobe. Halt then stays set until reset.
- R10: When several bits of [11:0] are set, only the highest-numbered set bit acts. Bit 11 has the highest priority and bit 0 the lowest. A field of all zeros does nothing.
- R11: The strobe is ignored, and AC, E, skip and halt are unchanged, when bits [14:12] are not 111 or bit 15 is 1. Without a strobe nothing changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| exec_strobe | input | 1 | Execute the presented word on this edge |
| instr_word | input | 16 | Instruction word: [15] indirect, [14:12] opcode, [11:0] operation field |
| acc_q | output | 16 | Accumulator |
| ext_q | output | 1 | Extend flag |
| skip_q | output | 1 | Skip request to the program counter, one-cycle pulse |
| halt_q | output | 1 | Sticky halt |

## Verification
Every result passes through exactly one register. The new accumulator, extend flag, skip pulse and halt flag therefore all appear on the first rising edge after the strobe is sampled. The skip pulse drops again one edge later unless another skip-producing word follows. The bench drives each word on a falling edge and advances a behavioural model at the next rising edge. It compares all four outputs at the following falling edge, so each comparison lands in the single cycle where the result is due. Back-to-back skips and halts are compared in the same way.

// File: rtl/regref_pkg.sv
package regref_pkg;

    localparam int INSTR_W  = 16;
    localparam int FIELD_W  = 12;
    localparam int OPC_LSB  = 12;
    localparam int OPC_W    = 3;
    localparam int IND_BIT  = INSTR_W - 1;
    localparam logic [OPC_W-1:0] OPC_REGOP = 3'b111;
    localparam int SEL_W    = $clog2(FIELD_W + 1);

    typedef enum logic [3:0] {
        OP_NONE,
        OP_HALT,
        OP_SKIP_EZ,
        OP_SKIP_ZERO,
        OP_SKIP_NEG,
        OP_SKIP_POS,
        OP_INC,
        OP_ROT_L,
        OP_ROT_R,
        OP_CMP_E,
        OP_CMP_AC,
        OP_CLR_E,
        OP_CLR_AC
    } rr_op_e;

    typedef struct packed {
        logic   go;
        rr_op_e op;
    } rr_ctrl_t;

    // Field bit index to operation. The order is fixed by the encoding.
    function automatic rr_op_e idx_to_op(input int idx);
        rr_op_e r;
        case (idx)
            11:      r = OP_CLR_AC;
            10:      r = OP_CLR_E;
            9:       r = OP_CMP_AC;
            8:       r = OP_CMP_E;
            7:       r = OP_ROT_R;
            6:       r = OP_ROT_L;
            5:       r = OP_INC;
            4:       r = OP_SKIP_POS;
            3:       r = OP_SKIP_NEG;
            2:       r = OP_SKIP_ZERO;
            1:       r = OP_SKIP_EZ;
            0:       r = OP_HALT;
            default: r = OP_NONE;
        endcase
        return r;
    endfunction

    function automatic logic is_regop(input logic [INSTR_W-1:0] w);
        return (w[IND_BIT] == 1'b0) &&
               (w[OPC_LSB +: OPC_W] == OPC_REGOP);
    endfunction

endpackage

// File: rtl/regref_decode.sv
module regref_decode
    import regref_pkg::*;
(
    input  logic               strobe,
    input  logic [INSTR_W-1:0] word,
    output rr_ctrl_t           ctrl
);

    logic [FIELD_W-1:0] field;
    logic [FIELD_W-1:0] grant;

    assign field = word[FIELD_W-1:0];

    // A bit is granted only if no higher-numbered bit is set.
    genvar g;
    generate
        for (g = 0; g < FIELD_W; g++) begin : g_grant
            if (g == FIELD_W - 1) begin : g_top
                assign grant[g] = field[g];
            end else begin : g_rest
                assign grant[g] = field[g] & ~(|field[FIELD_W-1:g+1]);
            end
        end
    endgenerate

    always_comb begin
        rr_op_e sel;
        sel = OP_NONE;
        for (int i = 0; i < FIELD_W; i++) begin
            if (grant[i]) sel = idx_to_op(i);
        end
        ctrl.go = strobe && is_regop(word);
        ctrl.op = sel;
    end

endmodule

// File: rtl/regref_alu.sv
module regref_alu
    import regref_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  rr_op_e            op,
    input  logic [DATA_W-1:0] acc,
    input  logic              ext,
    output logic [DATA_W-1:0] acc_nxt,
    output logic              ext_nxt,
    output logic              skip_req,
    output logic              halt_req
);

    localparam int MSB = DATA_W - 1;

    logic acc_zero;
    logic acc_neg;

    assign acc_zero = (acc == '0);
    assign acc_neg  = acc[MSB];

    always_comb begin
        acc_nxt  = acc;
        ext_nxt  = ext;
        skip_req = 1'b0;
        halt_req = 1'b0;
        unique case (op)
            OP_CLR_AC:    acc_nxt = '0;
            OP_CLR_E:     ext_nxt = 1'b0;
            OP_CMP_AC:    acc_nxt = ~acc;
            OP_CMP_E:     ext_nxt = ~ext;
            OP_ROT_R: begin
                acc_nxt = {ext, acc[MSB:1]};
                ext_nxt = acc[0];
            end
            OP_ROT_L: begin
                acc_nxt = {acc[MSB-1:0], ext};
                ext_nxt = acc[MSB];
            end
            OP_INC:       acc_nxt = acc + 1'b1;
            OP_SKIP_POS:  skip_req = ~acc_neg;
            OP_SKIP_NEG:  skip_req = acc_neg;
            OP_SKIP_ZERO: skip_req = acc_zero;
            OP_SKIP_EZ:   skip_req = ~ext;
            OP_HALT:      halt_req = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/regref_state.sv
module regref_state #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] acc_nxt,
    input  logic              ext_nxt,
    input  logic              skip_req,
    input  logic              halt_req,
    output logic [DATA_W-1:0] acc_q,
    output logic              ext_q,
    output logic              skip_q,
    output logic              halt_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            ext_q  <= 1'b0;
            skip_q <= 1'b0;
            halt_q <= 1'b0;
        end else begin
            skip_q <= load && skip_req;
            if (load) begin
                acc_q <= acc_nxt;
                ext_q <= ext_nxt;
                if (halt_req) halt_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/regref_exec_unit.sv
module regref_exec_unit
    import regref_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               exec_strobe,
    input  logic [INSTR_W-1:0] instr_word,
    output logic [DATA_W-1:0]  acc_q,
    output logic               ext_q,
    output logic               skip_q,
    output logic               halt_q
);

    rr_ctrl_t          ctrl;
    logic [DATA_W-1:0] acc_nxt;
    logic              ext_nxt;
    logic              skip_req;
    logic              halt_req;

    regref_decode u_dec (
        .strobe (exec_strobe),
        .word   (instr_word),
        .ctrl   (ctrl)
    );

    regref_alu #(.DATA_W(DATA_W)) u_alu (
        .op       (ctrl.op),
        .acc      (acc_q),
        .ext      (ext_q),
        .acc_nxt  (acc_nxt),
        .ext_nxt  (ext_nxt),
        .skip_req (skip_req),
        .halt_req (halt_req)
    );

    regref_state #(.DATA_W(DATA_W)) u_st (
        .clk      (clk),
        .rst      (rst),
        .load     (ctrl.go),
        .acc_nxt  (acc_nxt),
        .ext_nxt  (ext_nxt),
        .skip_req (skip_req),
        .halt_req (halt_req),
        .acc_q    (acc_q),
        .ext_q    (ext_q),
        .skip_q   (skip_q),
        .halt_q   (halt_q)
    );

endmodule

// File: rtl/regref_checks.sv
module regref_checks
    import regref_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               exec_strobe,
    input logic [INSTR_W-1:0] instr_word,
    input logic [DATA_W-1:0]  acc_q,
    input logic               ext_q,
    input logic               skip_q,
    input logic               halt_q
);

    logic valid_op;
    assign valid_op = exec_strobe && (instr_word[15:12] == 4'h7);

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (acc_q == '0 && !ext_q && !skip_q && !halt_q));

    a_r3_rotate_right: assert property (@(posedge clk) disable iff (rst)
        (exec_strobe && instr_word == 16'h7080) |=>
        (acc_q == {$past(ext_q), $past(acc_q[DATA_W-1:1])} && ext_q == $past(acc_q[0])));

    a_r4_rotate_left: assert property (@(posedge clk) disable iff (rst)
        (exec_strobe && instr_word == 16'h7040) |=>
        (acc_q == {$past(acc_q[DATA_W-2:0]), $past(ext_q)} && ext_q == $past(acc_q[DATA_W-1])));

    a_r5_inc_wraps: assert property (@(posedge clk) disable iff (rst)
        (exec_strobe && instr_word == 16'h7020) |=>
        (acc_q == DATA_W'($past(acc_q) + 1'b1) && $stable(ext_q)));

    a_r8_skip_after_strobe: assert property (@(posedge clk) disable iff (rst)
        skip_q |-> $past(valid_op));

    a_r9_halt_sticky: assert property (@(posedge clk) disable iff (rst)
        halt_q |=> halt_q);

    a_r9_halt_set: assert property (@(posedge clk) disable iff (rst)
        (exec_strobe && instr_word == 16'h7001) |=> halt_q);

    a_r11_ignored_hold: assert property (@(posedge clk) disable iff (rst)
        !valid_op |=> ($stable(acc_q) && $stable(ext_q) && !skip_q));

endmodule

bind regref_exec_unit regref_checks #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .exec_strobe (exec_strobe),
    .instr_word  (instr_word),
    .acc_q       (acc_q),
    .ext_q       (ext_q),
    .skip_q      (skip_q),
    .halt_q      (halt_q)
);

// File: tb/tb_regref_exec_unit.sv
`timescale 1ns/1ps
module tb_regref_exec_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        exec_strobe;
    logic [15:0] instr_word;
    logic [15:0] acc_q;
    logic        ext_q;
    logic        skip_q;
    logic        halt_q;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [15:0] m_acc;
    logic        m_e;
    logic        m_skip;
    logic        m_halt;

    always #10 clk = ~clk;

    regref_exec_unit dut (
        .clk         (clk),
        .rst         (rst),
        .exec_strobe (exec_strobe),
        .instr_word  (instr_word),
        .acc_q       (acc_q),
        .ext_q       (ext_q),
        .skip_q      (skip_q),
        .halt_q      (halt_q)
    );

    task automatic compare(input string tag);
        checks++;
        if (acc_q !== m_acc || ext_q !== m_e || skip_q !== m_skip || halt_q !== m_halt) begin
            fails++;
            $display("FAIL %s: got acc=%h e=%b skip=%b halt=%b, expected acc=%h e=%b skip=%b halt=%b",
                     tag, acc_q, ext_q, skip_q, halt_q, m_acc, m_e, m_skip, m_halt);
        end
    endtask

    // Behavioural model of one clock edge.
    task automatic model(input bit stb, input logic [15:0] w);
        int hi;
        m_skip = 1'b0;
        if (stb && w[15:12] == 4'h7) begin
            hi = -1;
            for (int b = 11; b >= 0; b--) if (hi < 0 && w[b]) hi = b;
            case (hi)
                11: m_acc = 16'h0000;
                10: m_e = 1'b0;
                9:  m_acc = m_acc ^ 16'hFFFF;
                8:  m_e = !m_e;
                7:  begin
                        logic c;
                        c = m_acc[0];
                        m_acc = (m_acc >> 1) | (m_e ? 16'h8000 : 16'h0000);
                        m_e = c;
                    end
                6:  begin
                        logic c;
                        c = m_acc[15];
                        m_acc = (m_acc << 1) | {15'd0, m_e};
                        m_e = c;
                    end
                5:  m_acc = m_acc + 16'd1;
                4:  m_skip = (m_acc < 16'h8000);
                3:  m_skip = (m_acc >= 16'h8000);
                2:  m_skip = (m_acc == 16'd0);
                1:  m_skip = (m_e == 1'b0);
                0:  m_halt = 1'b1;
                default: ;
            endcase
        end
    endtask

    task automatic step(input bit stb, input logic [15:0] w, input string tag);
        exec_strobe = stb;
        instr_word  = w;
        @(posedge clk);
        model(stb, w);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic do_reset(input string tag);
        rst = 1'b1;
        exec_strobe = 1'b0;
        instr_word = 16'h0000;
        repeat (2) @(posedge clk);
        m_acc = 0; m_e = 0; m_skip = 0; m_halt = 0;
        @(negedge clk);
        compare(tag);
        rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        exec_strobe = 1'b0;
        instr_word = 16'h0000;
        @(negedge clk);
        do_reset("R1 reset state");
        step(0, 16'h0000, "R1 idle after reset");

        // R2 clear and complement
        step(1, 16'h7200, "R2 complement AC");
        step(1, 16'h7100, "R2 complement E");
        step(1, 16'h7800, "R2 clear AC");
        step(1, 16'h7400, "R2 clear E");
        step(1, 16'h7100, "R2 complement E again");
        step(1, 16'h7200, "R2 complement AC again");

        // R5 increment wraps, E unchanged
        step(1, 16'h7020, "R5 increment FFFF wraps");
        step(1, 16'h7020, "R5 increment");
        step(1, 16'h7020, "R5 increment");

        // R3 and R4 rotates through E
        step(1, 16'h7080, "R3 rotate right");
        step(1, 16'h7080, "R3 rotate right");
        for (int k = 0; k < 17; k++) step(1, 16'h7040, "R4 rotate left");
        step(1, 16'h7400, "R2 clear E");
        for (int k = 0; k < 5; k++) step(1, 16'h7080, "R3 rotate right E clear");
        step(1, 16'h7040, "R4 rotate left");

        // R6 and R7 skips, R8 pulse width and no state change
        step(1, 16'h7800, "R2 clear AC");
        step(1, 16'h7010, "R6 skip positive on zero");
        step(0, 16'h7010, "R8 skip pulse drops");
        step(1, 16'h7008, "R6 skip negative not taken");
        step(1, 16'h7004, "R7 skip zero taken");
        step(1, 16'h7004, "R8 back-to-back skip");
        step(1, 16'h7002, "R7 skip E zero");
        step(1, 16'h7200, "R2 complement AC");
        step(1, 16'h7008, "R6 skip negative taken");
        step(1, 16'h7010, "R6 skip positive not taken");
        step(1, 16'h7004, "R7 skip zero not taken");
        step(1, 16'h7100, "R2 complement E");
        step(1, 16'h7002, "R7 skip E zero not taken");

        // R10 priority
        step(1, 16'h7FFF, "R10 all bits: clear AC wins");
        step(1, 16'h7030, "R10 increment over skip");
        step(1, 16'h7003, "R10 skip-E over halt");
        step(1, 16'h7180, "R10 complement E over rotate");
        step(1, 16'h7000, "R10 empty field no-op");

        // R11 ignored strobes
        step(1, 16'hF800, "R11 indirect bit set ignored");
        step(1, 16'h0800, "R11 opcode 000 ignored");
        step(1, 16'h6200, "R11 opcode 110 ignored");
        step(1, 16'hF001, "R11 indirect halt ignored");
        step(0, 16'h7200, "R11 no strobe ignored");

        // R9 halt sticky
        step(1, 16'h7001, "R9 halt set");
        step(0, 16'h0000, "R9 halt holds");
        step(1, 16'h7020, "R9 halt holds over increment");
        do_reset("R9 reset clears halt");
        step(0, 16'h0000, "R1 idle after second reset");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule